// File: doc/BRIEF.md
# Non-Temporal Write-Combining Store Buffer

This block takes stores that are marked as streaming (not to be reused soon) and sends them to memory without placing them in a data cache. Each store carries a word address, a 64-bit data word and an 8-bit byte mask. The first store that touches a line opens a line-sized combining entry. One cycle later the block asks the cache to drop any copy of that line it holds. Later stores to the same line merge into the same entry, and a later byte replaces an earlier one. An entry leaves as a single memory write. Its byte enables equal the bytes that were collected. Memory is never read, so the rest of the line stays as it was.

An entry is written out when all its bytes are filled, when a new line needs room and every entry is taken, or when a fence is requested. A fence closes the input, writes out every entry, and then raises a one-cycle done pulse. Entries for different lines may reach memory in any order. An entry is never written to memory before the cache has acknowledged its invalidate.

Top module: `ntwc_store_buffer`

## Requirements
- R1: After reset, `st_ready` is 1 and `mem_valid`, `probe_valid` and `fence_done` are 0.
- R2: A store with a non-zero mask whose line has no open entry is accepted into a new entry. In the cycle after acceptance, `probe_valid` is 1 and `probe_line` equals the store's line, which is `st_addr` without its low 3 word-select bits. A store that merges into an open entry raises no probe.
- R3: No line is written to memory before the probe for the entry holding it has been acknowledged with `probe_ack`.
- R4: Stores to the same line merge into one memory write. For each byte, the most recently accepted data is the value written.
- R5: Only bytes whose mask bit is 1 are written. Mask bit b selects data bits 8b+7..8b, at byte position 8·word+b of the line. Every other byte in memory keeps its previous value.
- R6: A store with an all-zero mask is accepted and has no effect: it raises no probe, opens no entry and causes no memory write.
- R7: An entry whose 64 bytes are all filled is written out without a fence, with `mem_be` all ones.
- R8: A store to a new line while all four entries are occupied waits with `st_ready` low. The oldest entry is written out first, and then the store is accepted.
- R9: After `fence_req`, `st_ready` stays low and every open entry is written out. Then `fence_done` is 1 for exactly one cycle, and no entry remains open at that point.
- R10: Each entry produces exactly one memory write, and `mem_be` is never all zero while `mem_valid` is 1.
- R11: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_line`, `mem_be` and `mem_data` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted when high with st_valid |
| st_addr | input | 29 | Store address in units of 8-byte words |
| st_data | input | 64 | Store data |
| st_mask | input | 8 | Per-byte write mask |
| probe_valid | output | 1 | Cache invalidate request pending |
| probe_line | output | 26 | Line address to invalidate |
| probe_ack | input | 1 | Cache has dropped the line |
| mem_valid | output | 1 | Memory line write valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_line | output | 26 | Line address of the write |
| mem_data | output | 512 | Line data |
| mem_be | output | 64 | Byte enables of the write |
| fence_req | input | 1 | Request to write out every entry |
| fence_done | output | 1 | One-cycle pulse when the fence has finished |

## Verification
The hardest case to reach is a fifth line arriving while all four entries are occupied. The oldest entry has to be chosen, it may still be waiting for its invalidate acknowledge, and the stalled store has to be taken once room appears. The bench opens four lines with partial masks, so none of them fills, then sends a store to a fifth line. It checks that the store stalls and that the first line opened is the first line written. A separate test slows both the probe acknowledge and the memory ready. A fence then overlaps a pending invalidate with a held memory write.

// File: rtl/ntwc_pkg.sv
package ntwc_pkg;
  typedef enum logic {
    DR_IDLE  = 1'b0,
    DR_WRITE = 1'b1
  } drain_st_e;
endpackage

// File: rtl/ntwc_line_store.sv
module ntwc_line_store #(
  parameter int NUM_ENT    = 4,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int IDX_W      = 2,
  parameter int WSEL_W     = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [WSEL_W-1:0]         wr_wsel,
  input  logic [WORD_BYTES*8-1:0]   wr_data,
  input  logic [WORD_BYTES-1:0]     wr_mask,
  input  logic                      clr_en,
  input  logic [IDX_W-1:0]          clr_idx,
  input  logic                      rd_en,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [LINE_BYTES*8-1:0]   rd_line,
  output logic [LINE_BYTES-1:0]     ent_mask [NUM_ENT]
);
  localparam int WORDS     = LINE_BYTES / WORD_BYTES;
  localparam int LINE_BITS = LINE_BYTES * 8;

  logic [LINE_BITS-1:0]  data_mem [NUM_ENT];
  logic [LINE_BITS-1:0]  rd_line_q;
  logic [LINE_BYTES-1:0] mask_q [NUM_ENT];
  logic [LINE_BYTES-1:0] wr_be_line;
  logic [LINE_BITS-1:0]  wr_data_line;

  // place the word's byte mask at its slot within the line
  always_comb begin
    wr_be_line   = {{(LINE_BYTES-WORD_BYTES){1'b0}}, wr_mask} << (WORD_BYTES * wr_wsel);
    wr_data_line = {WORDS{wr_data}};
  end

  // data array: byte-enable writes, registered read, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < LINE_BYTES; b++) begin
        if (wr_be_line[b]) data_mem[wr_idx][b*8 +: 8] <= wr_data_line[b*8 +: 8];
      end
    end
    if (rd_en) rd_line_q <= data_mem[rd_idx];
  end

  // collected-byte masks
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENT; i++) mask_q[i] <= '0;
    end else begin
      if (wr_en)  mask_q[wr_idx]  <= mask_q[wr_idx] | wr_be_line;
      if (clr_en) mask_q[clr_idx] <= '0;
    end
  end

  assign rd_line  = rd_line_q;
  assign ent_mask = mask_q;
endmodule

// File: rtl/ntwc_lookup.sv
module ntwc_lookup #(
  parameter int NUM_ENT    = 4,
  parameter int LINE_AW    = 26,
  parameter int LINE_BYTES = 64,
  parameter int AGE_W      = 3,
  parameter int IDX_W      = 2
) (
  input  logic [NUM_ENT-1:0]    ent_valid,
  input  logic [NUM_ENT-1:0]    ent_inv,
  input  logic [LINE_AW-1:0]    ent_line [NUM_ENT],
  input  logic [AGE_W-1:0]      ent_age  [NUM_ENT],
  input  logic [LINE_BYTES-1:0] ent_mask [NUM_ENT],
  input  logic [LINE_AW-1:0]    st_line,
  input  logic                  st_want,
  input  logic                  fence_active,
  output logic                  hit,
  output logic [IDX_W-1:0]      hit_idx,
  output logic                  free_any,
  output logic [IDX_W-1:0]      free_idx,
  output logic                  pick_valid,
  output logic [IDX_W-1:0]      pick_idx
);
  logic              old_found, drain_found, victim_req;
  logic [IDX_W-1:0]  old_idx, drain_idx;
  logic [AGE_W-1:0]  old_age;

  always_comb begin
    hit = 1'b0;  hit_idx = '0;
    free_any = 1'b0;  free_idx = '0;
    old_found = 1'b0;  old_idx = '0;  old_age = '0;
    drain_found = 1'b0;  drain_idx = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (ent_valid[i] && ent_line[i] == st_line && !hit) begin
        hit = 1'b1;  hit_idx = IDX_W'(i);
      end
      if (!ent_valid[i] && !free_any) begin
        free_any = 1'b1;  free_idx = IDX_W'(i);
      end
      if (ent_valid[i] && (!old_found || ent_age[i] > old_age)) begin
        old_found = 1'b1;  old_idx = IDX_W'(i);  old_age = ent_age[i];
      end
      if (ent_valid[i] && ent_inv[i] && (&ent_mask[i] || fence_active) && !drain_found) begin
        drain_found = 1'b1;  drain_idx = IDX_W'(i);
      end
    end
    victim_req = st_want && !hit && !free_any && !fence_active;
    pick_valid = drain_found || (victim_req && old_found && ent_inv[old_idx]);
    pick_idx   = drain_found ? drain_idx : old_idx;
  end
endmodule

// File: rtl/ntwc_drain.sv
module ntwc_drain import ntwc_pkg::*; #(
  parameter int IDX_W      = 2,
  parameter int LINE_AW    = 26,
  parameter int LINE_BYTES = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pick_valid,
  input  logic [IDX_W-1:0]      pick_idx,
  input  logic [LINE_AW-1:0]    pick_line,
  input  logic [LINE_BYTES-1:0] pick_mask,
  input  logic                  mem_ready,
  output logic                  mem_valid,
  output logic [LINE_AW-1:0]    mem_line,
  output logic [LINE_BYTES-1:0] mem_be,
  output logic                  busy,
  output logic                  start,
  output logic                  clr_en,
  output logic [IDX_W-1:0]      clr_idx
);
  drain_st_e             state_q;
  logic [IDX_W-1:0]      idx_q;
  logic [LINE_AW-1:0]    line_q;
  logic [LINE_BYTES-1:0] be_q;

  assign start = (state_q == DR_IDLE) && pick_valid;
  assign busy  = (state_q == DR_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DR_IDLE;
      idx_q   <= '0;
      line_q  <= '0;
      be_q    <= '0;
    end else begin
      case (state_q)
        DR_IDLE: if (pick_valid) begin
          state_q <= DR_WRITE;
          idx_q   <= pick_idx;
          line_q  <= pick_line;
          be_q    <= pick_mask;
        end
        DR_WRITE: if (mem_ready) state_q <= DR_IDLE;
        default: state_q <= DR_IDLE;
      endcase
    end
  end

  assign mem_valid = busy;
  assign mem_line  = line_q;
  assign mem_be    = be_q;
  assign clr_en    = busy && mem_ready;
  assign clr_idx   = idx_q;

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_line) && $stable(mem_be));

  a_r10_be_nonzero: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> mem_be != '0);
endmodule

// File: rtl/ntwc_store_buffer.sv
module ntwc_store_buffer import ntwc_pkg::*; #(
  parameter int ADDR_W     = 29,
  parameter int WORD_BYTES = 8,
  parameter int LINE_BYTES = 64,
  parameter int NUM_ENT    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      st_valid,
  output logic                      st_ready,
  input  logic [ADDR_W-1:0]         st_addr,
  input  logic [WORD_BYTES*8-1:0]   st_data,
  input  logic [WORD_BYTES-1:0]     st_mask,
  output logic                      probe_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES/WORD_BYTES)-1:0] probe_line,
  input  logic                      probe_ack,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic [ADDR_W-$clog2(LINE_BYTES/WORD_BYTES)-1:0] mem_line,
  output logic [LINE_BYTES*8-1:0]   mem_data,
  output logic [LINE_BYTES-1:0]     mem_be,
  input  logic                      fence_req,
  output logic                      fence_done
);
  localparam int WSEL_W  = $clog2(LINE_BYTES / WORD_BYTES);
  localparam int LINE_AW = ADDR_W - WSEL_W;
  localparam int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int AGE_W   = $clog2(NUM_ENT) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [LINE_AW-1:0]    st_line;
  logic [WSEL_W-1:0]     st_wsel;
  logic                  st_zero, accept, wr_en, alloc;
  logic [IDX_W-1:0]      wr_idx;

  logic [NUM_ENT-1:0]    ent_valid_q, ent_inv_q;
  logic [LINE_AW-1:0]    ent_line_q [NUM_ENT];
  logic [AGE_W-1:0]      ent_age_q  [NUM_ENT];
  logic [LINE_BYTES-1:0] ent_mask   [NUM_ENT];

  logic                  probe_pend_q;
  logic [LINE_AW-1:0]    probe_line_q;
  logic [IDX_W-1:0]      probe_idx_q;
  logic                  fence_active_q, fence_done_q, fence_empty;

  logic                  hit, free_any, pick_valid;
  logic [IDX_W-1:0]      hit_idx, free_idx, pick_idx;
  logic                  dr_busy, dr_start, clr_en;
  logic [IDX_W-1:0]      clr_idx;

  assign st_line = st_addr[ADDR_W-1:WSEL_W];
  assign st_wsel = st_addr[WSEL_W-1:0];
  assign st_zero = (st_mask == '0);

  ntwc_lookup #(
    .NUM_ENT(NUM_ENT), .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES),
    .AGE_W(AGE_W), .IDX_W(IDX_W)
  ) u_lookup (
    .ent_valid(ent_valid_q), .ent_inv(ent_inv_q), .ent_line(ent_line_q),
    .ent_age(ent_age_q), .ent_mask(ent_mask), .st_line(st_line),
    .st_want(st_valid && !st_zero), .fence_active(fence_active_q),
    .hit(hit), .hit_idx(hit_idx), .free_any(free_any), .free_idx(free_idx),
    .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  // input is closed while a probe is open, a drain runs or a fence is active
  assign st_ready = !fence_active_q && !probe_pend_q && !dr_busy && !dr_start &&
                    (st_zero || hit || free_any);
  assign accept   = st_valid && st_ready;
  assign wr_en    = accept && !st_zero;
  assign alloc    = wr_en && !hit;
  assign wr_idx   = hit ? hit_idx : free_idx;

  ntwc_line_store #(
    .NUM_ENT(NUM_ENT), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES),
    .IDX_W(IDX_W), .WSEL_W(WSEL_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_wsel(st_wsel),
    .wr_data(st_data), .wr_mask(st_mask),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .rd_en(dr_start), .rd_idx(pick_idx),
    .rd_line(mem_data), .ent_mask(ent_mask)
  );

  ntwc_drain #(
    .IDX_W(IDX_W), .LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)
  ) u_drain (
    .clk(clk), .rst(rst),
    .pick_valid(pick_valid), .pick_idx(pick_idx),
    .pick_line(ent_line_q[pick_idx]), .pick_mask(ent_mask[pick_idx]),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_line(mem_line),
    .mem_be(mem_be), .busy(dr_busy), .start(dr_start),
    .clr_en(clr_en), .clr_idx(clr_idx)
  );

  assign fence_empty = (ent_valid_q == '0) && !probe_pend_q && !dr_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid_q    <= '0;
      ent_inv_q      <= '0;
      probe_pend_q   <= 1'b0;
      probe_line_q   <= '0;
      probe_idx_q    <= '0;
      fence_active_q <= 1'b0;
      fence_done_q   <= 1'b0;
      for (int i = 0; i < NUM_ENT; i++) begin
        ent_line_q[i] <= '0;
        ent_age_q[i]  <= '0;
      end
    end else begin
      fence_done_q <= 1'b0;
      if (alloc) begin
        for (int i = 0; i < NUM_ENT; i++) begin
          if (IDX_W'(i) == wr_idx) begin
            ent_valid_q[i] <= 1'b1;
            ent_inv_q[i]   <= 1'b0;
            ent_line_q[i]  <= st_line;
            ent_age_q[i]   <= '0;
          end else if (ent_valid_q[i] && ent_age_q[i] != AGE_MAX) begin
            ent_age_q[i] <= ent_age_q[i] + 1'b1;
          end
        end
        probe_pend_q <= 1'b1;
        probe_line_q <= st_line;
        probe_idx_q  <= wr_idx;
      end
      if (probe_pend_q && probe_ack) begin
        probe_pend_q           <= 1'b0;
        ent_inv_q[probe_idx_q] <= 1'b1;
      end
      if (clr_en) ent_valid_q[clr_idx] <= 1'b0;
      if (fence_active_q) begin
        if (fence_empty) begin
          fence_active_q <= 1'b0;
          fence_done_q   <= 1'b1;
        end
      end else if (fence_req) begin
        fence_active_q <= 1'b1;
      end
    end
  end

  assign probe_valid = probe_pend_q;
  assign probe_line  = probe_line_q;
  assign fence_done  = fence_done_q;

  a_r2_probe_next: assert property (@(posedge clk) disable iff (rst)
    alloc |=> probe_valid && probe_line == $past(st_line));

  a_r3_no_write_before_inv: assert property (@(posedge clk) disable iff (rst)
    mem_valid && probe_valid |-> clr_idx != probe_idx_q);

  a_r6_zero_no_probe: assert property (@(posedge clk) disable iff (rst)
    accept && st_zero |=> !probe_valid);

  a_r9_done_clean: assert property (@(posedge clk) disable iff (rst)
    fence_done |-> ent_valid_q == '0 && !mem_valid);

  a_r9_done_once: assert property (@(posedge clk) disable iff (rst)
    fence_done |=> !fence_done);
endmodule

// File: tb/ntwc_store_buffer_bench.sv
module ntwc_store_buffer_bench;
  localparam int CLK_P = 10;
  localparam int NLINES = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [28:0]  st_addr = '0;
  logic [63:0]  st_data = '0;
  logic [7:0]   st_mask = '0;
  logic         probe_valid;
  logic [25:0]  probe_line;
  logic         probe_ack = 1'b0;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [25:0]  mem_line;
  logic [511:0] mem_data;
  logic [63:0]  mem_be;
  logic         fence_req = 1'b0;
  logic         fence_done;

  int n_chk = 0, n_bad = 0;
  int probe_lat = 1, mem_lat = 0, pcnt = 0, mcnt = 0;
  int wr_count = 0;
  int wr_line_log [64];
  logic [63:0] wr_be_log [64];
  logic [7:0] mem_img [NLINES*64];
  logic [7:0] exp_img [NLINES*64];
  bit probed [NLINES];
  bit hold = 0;
  logic [25:0] h_line; logic [63:0] h_be; logic [511:0] h_data;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  ntwc_store_buffer u_ntwc_store_buffer (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_mask(st_mask),
    .probe_valid(probe_valid), .probe_line(probe_line), .probe_ack(probe_ack),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_line(mem_line),
    .mem_data(mem_data), .mem_be(mem_be),
    .fence_req(fence_req), .fence_done(fence_done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cache and memory responders, driven away from the active edge
  always @(negedge clk) begin
    if (probe_valid) begin pcnt++; probe_ack <= (pcnt > probe_lat); end
    else begin pcnt = 0; probe_ack <= 1'b0; end
    if (mem_valid) begin mcnt++; mem_ready <= (mcnt > mem_lat); end
    else begin mcnt = 0; mem_ready <= 1'b0; end
  end

  // memory monitor
  always @(posedge clk) begin
    if (!rst) begin
      if (probe_valid && probe_ack) probed[int'(probe_line[3:0])] = 1'b1;
      if (hold) chk(mem_valid && mem_line == h_line && mem_be == h_be && mem_data == h_data,
                    "R11 write held stable", {38'd0, mem_line}, {38'd0, h_line});
      hold = mem_valid && !mem_ready;
      h_line = mem_line; h_be = mem_be; h_data = mem_data;
      if (mem_valid && mem_ready) begin
        chk(mem_be != '0, "R10 nonzero byte enables", mem_be, 64'd1);
        chk(probed[int'(mem_line[3:0])], "R3 invalidate acknowledged before write",
            0, 1);
        probed[int'(mem_line[3:0])] = 1'b0;
        for (int b = 0; b < 64; b++)
          if (mem_be[b]) mem_img[int'(mem_line[3:0])*64 + b] = mem_data[b*8 +: 8];
        if (wr_count < 64) begin
          wr_line_log[wr_count] = int'(mem_line);
          wr_be_log[wr_count] = mem_be;
        end
        wr_count++;
      end
    end
  end

  task automatic do_store(input int line, input int word, input logic [63:0] d,
                          input logic [7:0] m, input bit exp_new, input string req,
                          output int waited);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 29'(line*8 + word); st_data = d; st_mask = m;
    waited = 0;
    #1;
    while (!st_ready && waited < 500) begin @(negedge clk); #1; waited++; end
    @(posedge clk); #1;
    st_valid = 1'b0;
    for (int b = 0; b < 8; b++) if (m[b]) exp_img[line*64 + word*8 + b] = d[b*8 +: 8];
    @(negedge clk);
    chk(probe_valid == exp_new, req, {63'd0, probe_valid}, {63'd0, exp_new});
    if (exp_new) chk(probe_line == 26'(line), "R2 probe line", {38'd0, probe_line}, 64'(line));
  endtask

  task automatic run_fence(input int exp_w, input string req);
    int base, cyc;
    bit seen;
    base = wr_count; seen = 0;
    @(negedge clk); fence_req = 1'b1;
    @(negedge clk); fence_req = 1'b0;
    chk(!st_ready, "R9 ready low during fence", {63'd0, st_ready}, 64'd0);
    for (cyc = 0; cyc < 400; cyc++) begin
      if (fence_done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, "R9 fence done raised", {63'd0, seen}, 64'd1);
    chk(wr_count - base == exp_w, req, 64'(wr_count - base), 64'(exp_w));
    @(negedge clk);
    chk(!fence_done, "R9 fence done one cycle", {63'd0, fence_done}, 64'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(st_ready, "R1 ready after reset", {63'd0, st_ready}, 64'd1);
    chk(!mem_valid && !probe_valid && !fence_done, "R1 outputs idle after reset",
        {61'd0, mem_valid, probe_valid, fence_done}, 64'd0);
  endtask

  task automatic t_merge;
    int w;
    do_store(1, 0, 64'h1111_2222_3333_4444, 8'h0F, 1, "R2 new line probes", w);
    do_store(1, 0, 64'hAAAA_BBBB_CCCC_DDDD, 8'h3C, 0, "R2 merge raises no probe", w);
    do_store(1, 5, 64'h9900_0000_0000_0000, 8'h80, 0, "R2 merge raises no probe", w);
    run_fence(1, "R4 merged line one write");
    chk(wr_be_log[wr_count-1] == 64'h0000_8000_0000_003F, "R5 byte enables = collected mask",
        wr_be_log[wr_count-1], 64'h0000_8000_0000_003F);
    chk(wr_line_log[wr_count-1] == 1, "R4 merged line address", 64'(wr_line_log[wr_count-1]), 64'd1);
  endtask

  task automatic t_zero;
    int w, base;
    base = wr_count;
    do_store(2, 3, 64'hDEAD_BEEF_DEAD_BEEF, 8'h00, 0, "R6 zero mask no probe", w);
    chk(w == 0, "R6 zero mask accepted", 64'(w), 64'd0);
    run_fence(0, "R6 zero mask no write");
    chk(wr_count == base, "R6 no write", 64'(wr_count), 64'(base));
  endtask

  task automatic t_full;
    int w, base, cyc;
    base = wr_count;
    for (int k = 0; k < 8; k++)
      do_store(3, k, {8{8'(8'h30 + k)}}, 8'hFF, k == 0, "R2 probe only on first", w);
    for (cyc = 0; cyc < 60 && wr_count == base; cyc++) @(negedge clk);
    chk(wr_count == base + 1, "R7 full line written without fence", 64'(wr_count - base), 64'd1);
    chk(wr_be_log[base] == '1, "R7 full byte enables", wr_be_log[base], '1);
    chk(wr_line_log[base] == 3, "R7 full line address", 64'(wr_line_log[base]), 64'd3);
  endtask

  task automatic t_evict;
    int w, base;
    for (int l = 4; l < 8; l++)
      do_store(l, 1, {8{8'(8'h40 + l)}}, 8'h01 << (l - 4), 1, "R2 new line probes", w);
    base = wr_count;
    do_store(8, 2, 64'h0102_0304_0506_0708, 8'hC3, 1, "R8 stalled store opens entry", w);
    chk(w > 0, "R8 ready low while entries full", 64'(w), 64'd1);
    chk(wr_count > base && wr_line_log[base] == 4, "R8 oldest entry written first",
        64'(wr_line_log[base]), 64'd4);
    run_fence(4, "R10 one write per remaining entry");
  endtask

  task automatic t_slow;
    int w;
    probe_lat = 8; mem_lat = 4;
    do_store(9, 2, 64'h5A5A_5A5A_5A5A_5A5A, 8'hF0, 1, "R2 new line probes", w);
    do_store(10, 7, 64'hA5A5_A5A5_A5A5_A5A5, 8'h0F, 1, "R2 new line probes", w);
    run_fence(2, "R9 fence writes every open entry");
    probe_lat = 1; mem_lat = 0;
  endtask

  task automatic t_image;
    int bad;
    bad = 0;
    for (int i = 0; i < NLINES*64; i++) if (mem_img[i] !== exp_img[i]) bad++;
    chk(bad == 0, "R5 memory image masked bytes only (R4 last write wins)", 64'(bad), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < NLINES*64; i++) begin
      mem_img[i] = 8'(i*7 + 3);
      exp_img[i] = 8'(i*7 + 3);
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_merge();
    t_zero();
    t_full();
    t_evict();
    t_slow();
    t_image();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    #(CLK_P*100000);
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog expired", 0, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    end
    $finish;
  end
endmodule